// File: doc/BRIEF.md
# TDM Timeslot Test Pattern Inserter

This block sits in a byte-wide time-division-multiplexed stream and overwrites the payload of one chosen timeslot on one chosen link with a test pattern. Each input beat carries a data byte, a link index, a timeslot index, a frame-start flag and a valid strobe. The output stream has the same shape and follows the input by one clock cycle. Every byte passes through unchanged except the single byte whose link and timeslot match the programmed pair.

The pattern is either a pseudo-random bit sequence from an 11-bit shift register with polynomial x^11 + x^9 + 1, or a static byte that software programs. A small register port sets the link, the timeslot, the mode and the static byte, and reads back a wrapping count of substituted bytes. Writes land in staging registers. The datapath picks them up only on a valid frame-start beat, so a frame never mixes two configurations.

Two reset sources return everything to its defaults: an asynchronous active-low power-on reset and a synchronous active-high soft reset.

Top module: `tdm_slot_inserter`

## Requirements
- R1: After power-on reset, out_valid is 0 and register reads return 0 at every address: 0 is control (bit 0 enable, bit 1 mode, where 1 selects the static byte), 1 is link [5:0], 2 is timeslot [8:0], 3 is static byte [7:0], and 4 is the substitution count. Any other address also reads 0.
- R2: Every input beat appears at the output exactly one cycle later, with valid, frame-start, link and timeslot unchanged.
- R3: A byte is substituted only when it is valid, substitution is enabled, and its link and timeslot both equal the programmed values. Every other byte is forwarded unchanged.
- R4: A programmed link value of 60 to 63 never matches, and a beat whose link index is 60 or above is never altered.
- R5: In PRBS mode, each substituted byte holds the next 8 output bits of the x^11 + x^9 + 1 sequence, MSB first. The output bit is stage 11 and the feedback is stage 11 XOR stage 9. The generator advances only on substituted PRBS bytes, so the sequence carries on across frames.
- R6: In static mode, the substituted byte equals the programmed static byte, and the PRBS state does not advance.
- R7: Register writes change nothing in the stream until a beat with both valid and frame-start set. That beat and all later beats use the new values.
- R8: The generator starts from all ones after either reset and whenever enable goes from 0 to 1 at a frame-start. The first PRBS byte after such a start is 0xFF, and the state is never all zeros.
- R9: The count at address 4 goes up by one for each substituted byte and wraps to 0 past its maximum. Writes to address 4 have no effect.
- R10: A soft reset pulse clears out_valid on the next cycle and returns every register, the active configuration, the count and the generator seed to their power-on values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| soft_rst | input | 1 | Synchronous active-high soft reset |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | Input beat is the first of a frame |
| in_link | input | LINK_W (6) | Link index of the input beat |
| in_slot | input | SLOT_W (9) | Timeslot index of the input beat |
| in_data | input | DATA_W (8) | Payload byte |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address for write and read |
| cfg_wdata | input | REG_W (16) | Register write data |
| cfg_rdata | output | REG_W (16) | Register read data, combinational from cfg_addr |
| out_valid | output | 1 | Output beat valid |
| out_sof | output | 1 | Output frame-start |
| out_link | output | LINK_W (6) | Output link index |
| out_slot | output | SLOT_W (9) | Output timeslot index |
| out_data | output | DATA_W (8) | Output payload, substituted when matched |

## Verification
The bench writes the enable bit partway through a frame. A design that applies staging values at once would overwrite the target slot in that frame, and the reference model flags it. The bench also re-enables after a disable to check that the first byte is 0xFF again: a design that skips the reseed carries the old sequence forward. Further frames cover link 59, timeslot 511 and link values 60 to 63, where a design that checks only equality would alter bytes it must leave alone. A long run on a single pair wraps the count, and a soft reset arrives mid-stream. Together these catch counters that saturate, registers that accept writes at address 4, and state that a soft reset leaves behind.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  // Register address map of the configuration port
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_LINK   = 3'd1,
    REG_SLOT   = 3'd2,
    REG_STATIC = 3'd3,
    REG_COUNT  = 3'd4
  } reg_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 1;
endpackage

// File: rtl/tsi_cfg_regs.sv
module tsi_cfg_regs #(
  parameter int LINK_W = 6,
  parameter int SLOT_W = 9,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [CNT_W-1:0]  sub_cnt,
  output logic              sh_en,
  output logic              sh_static,
  output logic [LINK_W-1:0] sh_link,
  output logic [SLOT_W-1:0] sh_slot,
  output logic [DATA_W-1:0] sh_pat,
  output logic [REG_W-1:0]  cfg_rdata
);
  import tsi_pkg::*;

  logic              en_d, static_d;
  logic [LINK_W-1:0] link_d;
  logic [SLOT_W-1:0] slot_d;
  logic [DATA_W-1:0] pat_d;

  always_comb begin
    en_d     = sh_en;
    static_d = sh_static;
    link_d   = sh_link;
    slot_d   = sh_slot;
    pat_d    = sh_pat;
    if (cfg_wr) begin
      case (cfg_addr)
        REG_CTRL: begin
          en_d     = cfg_wdata[CTRL_EN_BIT];
          static_d = cfg_wdata[CTRL_MODE_BIT];
        end
        REG_LINK:   link_d = cfg_wdata[LINK_W-1:0];
        REG_SLOT:   slot_d = cfg_wdata[SLOT_W-1:0];
        REG_STATIC: pat_d  = cfg_wdata[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en     <= 1'b0;
      sh_static <= 1'b0;
      sh_link   <= '0;
      sh_slot   <= '0;
      sh_pat    <= '0;
    end else if (soft_rst) begin
      sh_en     <= 1'b0;
      sh_static <= 1'b0;
      sh_link   <= '0;
      sh_slot   <= '0;
      sh_pat    <= '0;
    end else if (cfg_wr) begin
      sh_en     <= en_d;
      sh_static <= static_d;
      sh_link   <= link_d;
      sh_slot   <= slot_d;
      sh_pat    <= pat_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      REG_CTRL: begin
        cfg_rdata[CTRL_EN_BIT]   = sh_en;
        cfg_rdata[CTRL_MODE_BIT] = sh_static;
      end
      REG_LINK:   cfg_rdata[LINK_W-1:0] = sh_link;
      REG_SLOT:   cfg_rdata[SLOT_W-1:0] = sh_slot;
      REG_STATIC: cfg_rdata[DATA_W-1:0] = sh_pat;
      REG_COUNT:  cfg_rdata[CNT_W-1:0]  = sub_cnt;
      default: ;
    endcase
  end
endmodule

// File: rtl/tsi_slot_match.sv
module tsi_slot_match #(
  parameter int LINK_W    = 6,
  parameter int SLOT_W    = 9,
  parameter int DATA_W    = 8,
  parameter int NUM_LINKS = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              beat_valid,
  input  logic              beat_sof,
  input  logic [LINK_W-1:0] beat_link,
  input  logic [SLOT_W-1:0] beat_slot,
  input  logic              sh_en,
  input  logic              sh_static,
  input  logic [LINK_W-1:0] sh_link,
  input  logic [SLOT_W-1:0] sh_slot,
  input  logic [DATA_W-1:0] sh_pat,
  output logic              fire,
  output logic              eff_static,
  output logic [DATA_W-1:0] eff_pat,
  output logic              reseed
);
  localparam int LINK_SPACE = 1 << LINK_W;

  logic              act_en, act_static;
  logic [LINK_W-1:0] act_link;
  logic [SLOT_W-1:0] act_slot;
  logic [DATA_W-1:0] act_pat;
  logic              load;
  logic              eff_en;
  logic [LINK_W-1:0] eff_link;
  logic [SLOT_W-1:0] eff_slot;
  logic              link_ok;

  assign load = beat_valid & beat_sof;

  // Frame-start beat sees staging values directly
  always_comb begin
    eff_en     = load ? sh_en     : act_en;
    eff_static = load ? sh_static : act_static;
    eff_link   = load ? sh_link   : act_link;
    eff_slot   = load ? sh_slot   : act_slot;
    eff_pat    = load ? sh_pat    : act_pat;
  end

  generate
    if (NUM_LINKS < LINK_SPACE) begin : g_range
      assign link_ok = (eff_link < LINK_W'(NUM_LINKS));
    end else begin : g_full
      assign link_ok = 1'b1;
    end
  endgenerate

  assign fire   = beat_valid & eff_en & link_ok &
                  (eff_link == beat_link) & (eff_slot == beat_slot);
  assign reseed = load & sh_en & ~act_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en     <= 1'b0;
      act_static <= 1'b0;
      act_link   <= '0;
      act_slot   <= '0;
      act_pat    <= '0;
    end else if (soft_rst) begin
      act_en     <= 1'b0;
      act_static <= 1'b0;
      act_link   <= '0;
      act_slot   <= '0;
      act_pat    <= '0;
    end else if (load) begin
      act_en     <= sh_en;
      act_static <= sh_static;
      act_link   <= sh_link;
      act_slot   <= sh_slot;
      act_pat    <= sh_pat;
    end
  end
endmodule

// File: rtl/tsi_prbs_gen.sv
module tsi_prbs_gen #(
  parameter int LFSR_W = 11,
  parameter int TAP_HI = 11,
  parameter int TAP_LO = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              reseed,
  input  logic              advance,
  output logic [DATA_W-1:0] pat_byte,
  output logic [LFSR_W-1:0] state_q
);
  logic [LFSR_W-1:0] base;
  logic [LFSR_W-1:0] walk;
  logic [LFSR_W-1:0] state_d;

  always_comb begin
    base = reseed ? {LFSR_W{1'b1}} : state_q;
    walk = base;
    pat_byte = '0;
    for (int k = 0; k < DATA_W; k++) begin
      pat_byte[DATA_W-1-k] = walk[LFSR_W-1];
      walk = {walk[LFSR_W-2:0], walk[TAP_HI-1] ^ walk[TAP_LO-1]};
    end
    state_d = advance ? walk : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= {LFSR_W{1'b1}};
    end else if (soft_rst) begin
      state_q <= {LFSR_W{1'b1}};
    end else if (advance || reseed) begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/tdm_slot_inserter.sv
module tdm_slot_inserter #(
  parameter int LINK_W    = 6,
  parameter int SLOT_W    = 9,
  parameter int DATA_W    = 8,
  parameter int NUM_LINKS = 60,
  parameter int LFSR_W    = 11,
  parameter int TAP_HI    = 11,
  parameter int TAP_LO    = 9,
  parameter int CNT_W     = 16,
  parameter int REG_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [LINK_W-1:0] in_link,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              out_valid,
  output logic              out_sof,
  output logic [LINK_W-1:0] out_link,
  output logic [SLOT_W-1:0] out_slot,
  output logic [DATA_W-1:0] out_data
);
  logic              sh_en, sh_static;
  logic [LINK_W-1:0] sh_link;
  logic [SLOT_W-1:0] sh_slot;
  logic [DATA_W-1:0] sh_pat;
  logic              sub_fire, eff_static, reseed;
  logic [DATA_W-1:0] eff_pat, prbs_byte;
  logic [LFSR_W-1:0] prbs_state;
  logic [CNT_W-1:0]  sub_cnt_q, sub_cnt_d;
  logic [DATA_W-1:0] data_d;

  tsi_cfg_regs #(
    .LINK_W(LINK_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .REG_W(REG_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sub_cnt(sub_cnt_q),
    .sh_en(sh_en), .sh_static(sh_static), .sh_link(sh_link),
    .sh_slot(sh_slot), .sh_pat(sh_pat), .cfg_rdata(cfg_rdata)
  );

  tsi_slot_match #(
    .LINK_W(LINK_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W), .NUM_LINKS(NUM_LINKS)
  ) u_match (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .beat_valid(in_valid), .beat_sof(in_sof),
    .beat_link(in_link), .beat_slot(in_slot),
    .sh_en(sh_en), .sh_static(sh_static), .sh_link(sh_link),
    .sh_slot(sh_slot), .sh_pat(sh_pat),
    .fire(sub_fire), .eff_static(eff_static), .eff_pat(eff_pat), .reseed(reseed)
  );

  tsi_prbs_gen #(
    .LFSR_W(LFSR_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .DATA_W(DATA_W)
  ) u_prbs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .reseed(reseed), .advance(sub_fire & ~eff_static),
    .pat_byte(prbs_byte), .state_q(prbs_state)
  );

  always_comb begin
    if (sub_fire) data_d = eff_static ? eff_pat : prbs_byte;
    else          data_d = in_data;
    sub_cnt_d = sub_cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             sub_cnt_q <= '0;
    else if (soft_rst)      sub_cnt_q <= '0;
    else if (sub_fire)      sub_cnt_q <= sub_cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (soft_rst) out_valid <= 1'b0;
    else               out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sof  <= 1'b0;
      out_link <= '0;
      out_slot <= '0;
      out_data <= '0;
    end else if (in_valid && !soft_rst) begin
      out_sof  <= in_sof;
      out_link <= in_link;
      out_slot <= in_slot;
      out_data <= data_d;
    end
  end
endmodule

// File: rtl/tsi_checker.sv
module tsi_checker #(
  parameter int LINK_W    = 6,
  parameter int SLOT_W    = 9,
  parameter int DATA_W    = 8,
  parameter int NUM_LINKS = 60,
  parameter int LFSR_W    = 11,
  parameter int CNT_W     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              in_valid,
  input logic              in_sof,
  input logic [LINK_W-1:0] in_link,
  input logic [SLOT_W-1:0] in_slot,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_sof,
  input logic [LINK_W-1:0] out_link,
  input logic [SLOT_W-1:0] out_slot,
  input logic [DATA_W-1:0] out_data,
  input logic              fire,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [LFSR_W-1:0] lfsr_q
);
  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == ($past(in_valid) && !$past(soft_rst)));

  assert_tags_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !soft_rst) |=> (out_sof == $past(in_sof)) &&
      (out_link == $past(in_link)) && (out_slot == $past(in_slot)));

  assert_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !soft_rst && !fire) |=> out_data == $past(in_data));

  assert_high_link_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !soft_rst && (in_link >= LINK_W'(NUM_LINKS))) |=> out_data == $past(in_data));

  assert_lfsr_alive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> lfsr_q != '0);

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !soft_rst) |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !soft_rst) |=> $stable(cnt_q));

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cnt_q == '0) && !out_valid);
endmodule

bind tdm_slot_inserter tsi_checker #(
  .LINK_W(LINK_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W),
  .NUM_LINKS(NUM_LINKS), .LFSR_W(LFSR_W), .CNT_W(CNT_W)
) u_tsi_checker (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .in_valid(in_valid), .in_sof(in_sof), .in_link(in_link),
  .in_slot(in_slot), .in_data(in_data),
  .out_valid(out_valid), .out_sof(out_sof), .out_link(out_link),
  .out_slot(out_slot), .out_data(out_data),
  .fire(sub_fire), .cnt_q(sub_cnt_q), .lfsr_q(prbs_state)
);

// File: tb/tdm_slot_inserter_bench.sv
module tdm_slot_inserter_bench;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_rst;
  logic        in_valid, in_sof;
  logic [5:0]  in_link;
  logic [8:0]  in_slot;
  logic [7:0]  in_data;
  logic        cfg_wr;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        out_valid, out_sof;
  logic [5:0]  out_link;
  logic [8:0]  out_slot;
  logic [7:0]  out_data;

  always #10 clk = ~clk;

  tdm_slot_inserter #(.CNT_W(CW)) u_tdm_slot_inserter (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .in_valid(in_valid), .in_sof(in_sof), .in_link(in_link),
    .in_slot(in_slot), .in_data(in_data),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .out_valid(out_valid), .out_sof(out_sof), .out_link(out_link),
    .out_slot(out_slot), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int s_en, s_st, s_link, s_slot, s_pat;
  int a_en, a_st, a_link, a_slot, a_pat;
  int lfsr, cnt;
  int x_v, x_sof, x_link, x_slot, x_data;
  string x_tag;

  task automatic model_reset();
    s_en = 0; s_st = 0; s_link = 0; s_slot = 0; s_pat = 0;
    a_en = 0; a_st = 0; a_link = 0; a_slot = 0; a_pat = 0;
    lfsr = 'h7FF; cnt = 0;
    x_v = 0; x_sof = 0; x_link = 0; x_slot = 0; x_data = 0;
  endtask

  function automatic int model_read(int a);
    case (a)
      0: return s_en | (s_st << 1);
      1: return s_link;
      2: return s_slot;
      3: return s_pat;
      4: return cnt;
      default: return 0;
    endcase
  endfunction

  task automatic note(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(int v, int sof, int lk, int sl, int d,
                       int wr, int a, int wd, int srst, int rdchk, string tag);
    int e_en, e_st, e_link, e_slot, e_pat, base, dout, fire, rd_exp;
    @(negedge clk);
    note(out_valid == x_v[0], x_tag, "out_valid", int'(out_valid), x_v);
    if (x_v != 0) begin
      note(out_sof == x_sof[0] && out_link == 6'(x_link) && out_slot == 9'(x_slot),
           x_tag, "sof/link/slot", {out_sof, out_link, out_slot}, (x_sof << 15) | (x_link << 9) | x_slot);
      note(out_data == 8'(x_data), x_tag, "out_data", int'(out_data), x_data);
    end
    rd_exp = model_read(a);
    in_valid = v[0]; in_sof = sof[0]; in_link = 6'(lk); in_slot = 9'(sl); in_data = 8'(d);
    cfg_wr = wr[0]; cfg_addr = 3'(a); cfg_wdata = 16'(wd); soft_rst = srst[0];
    x_tag = tag;
    if (rdchk != 0) begin
      #1;
      note(cfg_rdata == 16'(rd_exp), tag, $sformatf("read addr %0d", a), int'(cfg_rdata), rd_exp);
    end
    if (srst != 0) begin
      model_reset();
    end else begin
      if (v != 0 && sof != 0) begin
        e_en = s_en; e_st = s_st; e_link = s_link; e_slot = s_slot; e_pat = s_pat;
      end else begin
        e_en = a_en; e_st = a_st; e_link = a_link; e_slot = a_slot; e_pat = a_pat;
      end
      base = lfsr;
      if (v != 0 && sof != 0 && s_en != 0 && a_en == 0) base = 'h7FF;
      if (v != 0 && sof != 0) begin
        a_en = s_en; a_st = s_st; a_link = s_link; a_slot = s_slot; a_pat = s_pat;
      end
      fire = (v != 0 && e_en != 0 && e_link < 60 && e_link == lk && e_slot == sl) ? 1 : 0;
      dout = d;
      if (fire != 0) begin
        cnt = (cnt + 1) % (1 << CW);
        if (e_st != 0) dout = e_pat;
        else begin
          dout = 0;
          for (int i = 0; i < 8; i++) begin
            dout = (dout << 1) | ((base >> 10) & 1);
            base = ((base << 1) | (((base >> 10) ^ (base >> 8)) & 1)) & 'h7FF;
          end
        end
      end
      lfsr = base;
      x_v = v; x_sof = sof; x_link = lk; x_slot = sl; x_data = dout & 255;
      if (wr != 0) begin
        case (a)
          0: begin s_en = wd & 1; s_st = (wd >> 1) & 1; end
          1: s_link = wd & 63;
          2: s_slot = wd & 511;
          3: s_pat = wd & 255;
          default: ;
        endcase
      end
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wreg(int a, int wd, string tag);
    cycle(0, 0, 0, 0, 0, 1, a, wd, 0, 0, tag);
  endtask

  task automatic rreg(int a, string tag);
    cycle(0, 0, 0, 0, 0, 0, a, 0, 0, 1, tag);
  endtask

  task automatic frame(int lo, int hi, int s0, int s1, string tag);
    for (int s = s0; s <= s1; s++)
      for (int l = lo; l <= hi; l++)
        cycle(1, (s == 0 && l == lo) ? 1 : 0, l, s, (s * 7 + l * 13 + 5) & 255,
              0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    x_tag = "R1";
    rst_n = 1'b0; soft_rst = 1'b0; in_valid = 1'b0; in_sof = 1'b0;
    in_link = '0; in_slot = '0; in_data = '0;
    cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rreg(a, "R1");
    // R2 / R3 pass-through with substitution off
    frame(0, 3, 0, 5, "R2");
    frame(0, 3, 0, 5, "R3");
    // program link 5 slot 37, PRBS; enable arrives mid-frame (R7)
    wreg(1, 5, "R7");
    wreg(2, 37, "R7");
    frame(4, 6, 0, 19, "R7");
    wreg(0, 1, "R7");
    frame(4, 6, 20, 39, "R7");
    rreg(4, "R7");
    // first frame after enable starts from all ones (R8), then continuity (R5)
    frame(4, 6, 0, 39, "R8");
    for (int f = 0; f < 4; f++) frame(4, 6, 0, 39, "R5");
    rreg(4, "R9");
    // static mode (R6)
    wreg(3, 'hA5, "R6");
    wreg(0, 3, "R6");
    rreg(0, "R6");
    frame(4, 6, 0, 39, "R6");
    frame(4, 6, 0, 39, "R6");
    // back to PRBS keeps the sequence where it stopped (R6)
    wreg(0, 1, "R6");
    frame(4, 6, 0, 39, "R6");
    // boundary: link 59, slot 511 (R3)
    wreg(1, 59, "R3");
    wreg(2, 511, "R3");
    frame(57, 59, 508, 511, "R3");
    frame(57, 59, 0, 0, "R3");
    frame(57, 59, 508, 511, "R3");
    // links 60..63 never match (R4)
    for (int lk = 60; lk < 64; lk++) begin
      wreg(1, lk, "R4");
      wreg(2, 2, "R4");
      frame(58, 63, 0, 3, "R4");
    end
    // disable then re-enable reseeds (R8)
    wreg(1, 10, "R8");
    wreg(2, 1, "R8");
    wreg(0, 0, "R8");
    frame(9, 11, 0, 3, "R8");
    wreg(0, 1, "R8");
    frame(9, 11, 0, 3, "R8");
    frame(9, 11, 0, 3, "R8");
    // counter wrap and read-only count (R9)
    wreg(1, 7, "R9");
    wreg(2, 3, "R9");
    for (int i = 0; i < 300; i++) cycle(1, (i == 0) ? 1 : 0, 7, 3, i & 255, 0, 0, 0, 0, 0, "R9");
    rreg(4, "R9");
    wreg(4, 'h55, "R9");
    rreg(4, "R9");
    // soft reset mid-stream (R10)
    frame(6, 8, 0, 4, "R10");
    cycle(1, 0, 7, 3, 9, 0, 0, 0, 1, 0, "R10");
    for (int a = 0; a < 5; a++) rreg(a, "R10");
    frame(6, 8, 0, 4, "R10");
    wreg(1, 6, "R10");
    wreg(2, 0, "R10");
    wreg(0, 1, "R10");
    frame(6, 8, 0, 2, "R10");
    idle(3, "R10");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule